// File: doc/BRIEF.md
# Registered single-port block RAM

This block is a synchronous single-port memory shaped like an FPGA embedded RAM tile. The address and write enable go into input registers on the input clock. The write data is committed to the array on that same edge. An input clock enable gates the input registers, and an input asynchronous clear resets them. A port never reads and writes in the same cycle. When a cycle carries a write, it only writes, and the read data keeps its previous value.

The read path is chosen at build time. In flow-through mode the read data comes combinationally from the array at the registered address. In registered mode the read data passes through an output register. That register sits on a separate output clock and has its own enable and asynchronous clear.

A build-time packing option splits the storage into two independent memories of half size. Each half has its own address, write data, write enable and read data. The two halves share the clocks, enables and clears. Neither half can reach the other half's words.

Top module: `spr_ram_top`

## Requirements
- R1: When `out_aclr` is asserted in registered mode, `a_q` goes to 0 at once, with no clock edge needed. The stored words are left unchanged.
- R2: When `in_ce` is low at an `inclk` edge, the input registers keep their values and nothing is written, even if the write enable is high.
- R3: An `inclk` edge with `in_ce` high and the write enable high stores the write data at the given address. A later read of that address returns it.
- R4: On the edge that performs a write, the read data does not show the new word. It keeps the value it had before that edge.
- R5: Read latency is counted from the `inclk` edge that captures a read address (write enable low). In flow-through mode (`OUT_REG`=0) the word appears at the read output right after that edge. In registered mode (`OUT_REG`=1) it appears after the next `outclk` edge.
- R6: When `out_ce` is low at an `outclk` edge, the registered read output keeps its value.
- R7: While `in_aclr` is asserted, no write happens. The registered address clears to 0, so a flow-through output shows the word at address 0 straight away.
- R8: With `PACKED`=1, there are two independent halves of 2^(`ADDR_W`-1) words each, addressed through `a_addr` and `b_addr`. Writes through one half never change what the other half reads, even at the same address value.
- R9: With `PACKED`=0, the `b_*` inputs are ignored and `b_q` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| inclk | input | 1 | Input-side clock: input registers and array writes |
| in_ce | input | 1 | Clock enable for the input registers |
| in_aclr | input | 1 | Asynchronous clear of the input registers, active high |
| outclk | input | 1 | Clock of the output register |
| out_ce | input | 1 | Clock enable for the output register |
| out_aclr | input | 1 | Asynchronous clear of the output register, active high |
| a_addr | input | LANE_AW | Address of port A (ADDR_W, or ADDR_W-1 when packed) |
| a_wdata | input | DATA_W | Write data of port A |
| a_we | input | 1 | Write enable of port A |
| a_q | output | DATA_W | Read data of port A |
| b_addr | input | LANE_AW | Address of half B (packed mode only) |
| b_wdata | input | DATA_W | Write data of half B |
| b_we | input | 1 | Write enable of half B |
| b_q | output | DATA_W | Read data of half B; 0 when not packed |

## Verification
A corrupted registered address or a stuck write-enable flop shows up on the first read that follows. The wrong word appears one edge later in flow-through mode, or two edges later in registered mode. A hold register that is not refreshed when it should be makes the read output jump during a write cycle instead of staying flat, which is visible on the same edge. A write that leaks across the two packed halves, or a write that slips through while the enable is low or the clear is asserted, stays hidden until that word is read back. The bench therefore re-reads every address it has disturbed and compares each one against its own model of the memory.

// File: rtl/spr_pkg.sv
package spr_pkg;

  // Address width of one lane: a packed build halves the storage per lane.
  function automatic int lane_aw(input int full_aw, input bit packed_mode);
    return packed_mode ? full_aw - 1 : full_aw;
  endfunction

  // Number of independent lanes built.
  function automatic int lane_count(input bit packed_mode);
    return packed_mode ? 2 : 1;
  endfunction

  // Words held by one lane.
  function automatic int lane_words(input int aw);
    return 1 << aw;
  endfunction

endpackage

// File: rtl/spr_in_stage.sv
module spr_in_stage #(
  parameter int AW = 6
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          aclr,
  input  logic [AW-1:0] addr,
  input  logic          we,
  output logic [AW-1:0] addr_r,
  output logic          we_r,
  output logic          wr_fire
);

  // A write is committed on an enabled edge, never while clear is held.
  assign wr_fire = ce & we & ~aclr;

  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) begin
      addr_r <= '0;
      we_r   <= 1'b0;
    end else if (ce) begin
      addr_r <= addr;
      we_r   <= we;
    end
  end

  // R2
  ce_hold_chk: assert property (@(posedge clk) disable iff (aclr)
    !ce |=> ($stable(addr_r) && $stable(we_r)));

endmodule

// File: rtl/spr_bank.sv
module spr_bank
  import spr_pkg::*;
#(
  parameter int AW = 6,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          aclr,
  input  logic          wr_fire,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] rd_addr,
  input  logic          we_r,
  output logic [DW-1:0] rd_data
);

  localparam int WORDS = lane_words(AW);

  logic [DW-1:0] mem [WORDS];
  logic [DW-1:0] hold_q;

  always_ff @(posedge clk) begin
    if (wr_fire) mem[waddr] <= wdata;
  end

  // The last value shown is kept so that a write cycle does not disturb the output.
  always_ff @(posedge clk or posedge aclr) begin
    if (aclr) hold_q <= '0;
    else      hold_q <= rd_data;
  end

  assign rd_data = we_r ? hold_q : mem[rd_addr];

  // R3
  wr_lands_chk: assert property (@(posedge clk) disable iff (aclr)
    wr_fire |=> (mem[rd_addr] == $past(wdata)));

  // R4
  wr_keeps_q_chk: assert property (@(posedge clk) disable iff (aclr)
    wr_fire |=> $stable(rd_data));

endmodule

// File: rtl/spr_out_stage.sv
module spr_out_stage #(
  parameter int DW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          clk,
  input  logic          ce,
  input  logic          aclr,
  input  logic [DW-1:0] d,
  output logic [DW-1:0] q
);

  generate
    if (OUT_REG) begin : g_reg
      logic [DW-1:0] q_r;
      always_ff @(posedge clk or posedge aclr) begin
        if (aclr)    q_r <= '0;
        else if (ce) q_r <= d;
      end
      assign q = q_r;

      // R6
      oce_hold_chk: assert property (@(posedge clk) disable iff (aclr)
        !ce |=> $stable(q));
    end else begin : g_flow
      logic unused_ctl;
      assign unused_ctl = clk ^ ce ^ aclr;
      assign q = d;
    end
  endgenerate

endmodule

// File: rtl/spr_lane.sv
module spr_lane #(
  parameter int AW      = 6,
  parameter int DW      = 8,
  parameter bit OUT_REG = 1'b1
) (
  input  logic          inclk,
  input  logic          in_ce,
  input  logic          in_aclr,
  input  logic          outclk,
  input  logic          out_ce,
  input  logic          out_aclr,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          we,
  output logic [DW-1:0] q
);

  logic [AW-1:0] addr_r;
  logic          we_r;
  logic          wr_fire;
  logic [DW-1:0] rd_flow;

  spr_in_stage #(.AW(AW)) u_in (
    .clk(inclk), .ce(in_ce), .aclr(in_aclr),
    .addr(addr), .we(we),
    .addr_r(addr_r), .we_r(we_r), .wr_fire(wr_fire)
  );

  spr_bank #(.AW(AW), .DW(DW)) u_bank (
    .clk(inclk), .aclr(in_aclr), .wr_fire(wr_fire),
    .waddr(addr), .wdata(wdata),
    .rd_addr(addr_r), .we_r(we_r), .rd_data(rd_flow)
  );

  spr_out_stage #(.DW(DW), .OUT_REG(OUT_REG)) u_out (
    .clk(outclk), .ce(out_ce), .aclr(out_aclr),
    .d(rd_flow), .q(q)
  );

endmodule

// File: rtl/spr_ram_top.sv
module spr_ram_top
  import spr_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int ADDR_W  = 6,
  parameter bit OUT_REG = 1'b1,
  parameter bit PACKED  = 1'b0,
  localparam int LANE_AW = lane_aw(ADDR_W, PACKED)
) (
  input  logic               inclk,
  input  logic               in_ce,
  input  logic               in_aclr,
  input  logic               outclk,
  input  logic               out_ce,
  input  logic               out_aclr,
  input  logic [LANE_AW-1:0] a_addr,
  input  logic [DATA_W-1:0]  a_wdata,
  input  logic               a_we,
  output logic [DATA_W-1:0]  a_q,
  input  logic [LANE_AW-1:0] b_addr,
  input  logic [DATA_W-1:0]  b_wdata,
  input  logic               b_we,
  output logic [DATA_W-1:0]  b_q
);

  localparam int LANES = lane_count(PACKED);

  logic [LANE_AW-1:0] l_addr  [LANES];
  logic [DATA_W-1:0]  l_wdata [LANES];
  logic               l_we    [LANES];
  logic [DATA_W-1:0]  l_q     [LANES];

  assign l_addr[0]  = a_addr;
  assign l_wdata[0] = a_wdata;
  assign l_we[0]    = a_we;
  assign a_q        = l_q[0];

  generate
    if (PACKED) begin : g_packed
      assign l_addr[1]  = b_addr;
      assign l_wdata[1] = b_wdata;
      assign l_we[1]    = b_we;
      assign b_q        = l_q[1];
    end else begin : g_single
      logic unused_b;
      assign unused_b = ^{b_addr, b_wdata, b_we};
      assign b_q = '0;
    end

    for (genvar i = 0; i < LANES; i++) begin : g_lane
      spr_lane #(.AW(LANE_AW), .DW(DATA_W), .OUT_REG(OUT_REG)) u_lane (
        .inclk(inclk), .in_ce(in_ce), .in_aclr(in_aclr),
        .outclk(outclk), .out_ce(out_ce), .out_aclr(out_aclr),
        .addr(l_addr[i]), .wdata(l_wdata[i]), .we(l_we[i]),
        .q(l_q[i])
      );
    end
  endgenerate

  // R9
  unpacked_b_zero_chk: assert property (@(posedge inclk)
    !PACKED |-> (b_q == '0));

endmodule

// File: tb/tb_spr_ram_top.sv
`timescale 1ns/1ps
module tb_spr_ram_top;

  localparam int DW = 8;
  localparam int AW = 6;

  logic clk = 1'b0;
  always #4 clk = ~clk;   // 125 MHz

  logic          in_ce = 1'b0, in_aclr = 1'b1, out_ce = 1'b0, out_aclr = 1'b1;
  logic [AW-1:0] a_addr = '0, b_addr = '0;
  logic [DW-1:0] a_wdata = '0, b_wdata = '0;
  logic          a_we = 1'b0, b_we = 1'b0;
  logic [DW-1:0] q_a, q_b, f_a, f_b;

  // Registered, unpacked build (defaults).
  spr_ram_top dut (
    .inclk(clk), .in_ce(in_ce), .in_aclr(in_aclr),
    .outclk(clk), .out_ce(out_ce), .out_aclr(out_aclr),
    .a_addr(a_addr), .a_wdata(a_wdata), .a_we(a_we), .a_q(q_a),
    .b_addr(b_addr), .b_wdata(b_wdata), .b_we(b_we), .b_q(q_b)
  );

  // Flow-through, packed build.
  spr_ram_top #(.OUT_REG(1'b0), .PACKED(1'b1)) dut_f (
    .inclk(clk), .in_ce(in_ce), .in_aclr(in_aclr),
    .outclk(clk), .out_ce(out_ce), .out_aclr(out_aclr),
    .a_addr(a_addr[AW-2:0]), .a_wdata(a_wdata), .a_we(a_we), .a_q(f_a),
    .b_addr(b_addr[AW-2:0]), .b_wdata(b_wdata), .b_we(b_we), .b_q(f_b)
  );

  // Bench model
  logic [DW-1:0] mu [64];
  logic [DW-1:0] ma [32];
  logic [DW-1:0] mb [32];
  logic [DW-1:0] fu = '0, ru = '0, fa = '0, fb = '0;
  int  n_chk = 0, n_bad = 0;
  bit  armed = 1'b0;
  bit  done  = 1'b0;

  function automatic logic [DW-1:0] pat(input int i, input int salt);
    return DW'(i * 37 + salt * 11 + 5);
  endfunction

  // Read-side value after an input edge, derived from the requirements.
  function automatic logic [DW-1:0] flow_after(input bit iclr, input bit ce, input bit we,
                                               input logic [DW-1:0] pre,
                                               input logic [DW-1:0] word_at,
                                               input logic [DW-1:0] word0);
    if (iclr)     return word0;
    else if (!ce) return pre;
    else if (we)  return pre;
    else          return word_at;
  endfunction

  task automatic chk(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // One cycle: drive at the falling edge, model at the rising edge, check at the next falling edge.
  task automatic step(input string tag, input bit ce, input bit oce, input bit iclr, input bit oclr,
                      input bit awe, input logic [AW-1:0] aad, input logic [DW-1:0] ad,
                      input bit bwe, input logic [AW-1:0] bad_a, input logic [DW-1:0] bd);
    logic [DW-1:0] pre_u, pre_a, pre_b;
    in_ce = ce; out_ce = oce; in_aclr = iclr; out_aclr = oclr;
    a_we = awe; a_addr = aad; a_wdata = ad;
    b_we = bwe; b_addr = bad_a; b_wdata = bd;
    #1;
    pre_u = iclr ? mu[0] : fu;
    pre_a = iclr ? ma[0] : fa;
    pre_b = iclr ? mb[0] : fb;
    if (armed && oclr) chk("R1 async clear of q", q_a, '0);
    if (armed && iclr) begin
      chk("R7 flow shows word 0 under input clear (A)", f_a, ma[0]);
      chk("R7 flow shows word 0 under input clear (B)", f_b, mb[0]);
    end
    @(posedge clk);
    ru = oclr ? '0 : (oce ? pre_u : ru);
    if (!iclr && ce && awe) mu[aad] = ad;
    if (!iclr && ce && awe) ma[aad[AW-2:0]] = ad;
    if (!iclr && ce && bwe) mb[bad_a[AW-2:0]] = bd;
    fu = flow_after(iclr, ce, awe, pre_u, mu[aad], mu[0]);
    fa = flow_after(iclr, ce, awe, pre_a, ma[aad[AW-2:0]], ma[0]);
    fb = flow_after(iclr, ce, bwe, pre_b, mb[bad_a[AW-2:0]], mb[0]);
    @(negedge clk);
    if (armed) begin
      chk({tag, " registered q"}, q_a, ru);
      chk({tag, " flow half A"}, f_a, fa);
      chk({tag, " flow half B"}, f_b, fb);
      chk("R9 unused half reads zero", q_b, '0);
    end
  endtask

  task automatic rd(input string tag, input logic [AW-1:0] aa, input logic [AW-1:0] ba);
    step(tag, 1, 1, 0, 0, 0, aa, '0, 0, ba, '0);
  endtask

  initial begin : watchdog
    #(8 * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd1234));
    repeat (3) @(negedge clk);
    chk("R1 q cleared in reset", q_a, '0);
    chk("R9 b_q zero in reset", q_b, '0);

    // Fill every word
    for (int i = 0; i < 64; i++)
      step("init", 1, 1, 0, 0, 1, AW'(i), pat(i, 0), 1, AW'(63 - i), pat(i, 3));
    rd("init", 6'd0, 6'd1);
    rd("init", 6'd1, 6'd2);
    armed = 1'b1;

    // R5 latency: alternating addresses
    rd("R5 read", 6'd30, 6'd3);
    rd("R5 read", 6'd31, 6'd4);
    rd("R5 read", 6'd62, 6'd30);
    rd("R5 read", 6'd2, 6'd17);

    // R3 write then read back
    step("R3 write", 1, 1, 0, 0, 1, 6'd12, 8'h3c, 1, 6'd12, 8'hc3);
    rd("R3 readback", 6'd12, 6'd12);
    rd("R3 readback", 6'd12, 6'd12);

    // R4 back-to-back writes keep q steady
    rd("R4 prime", 6'd40, 6'd8);
    step("R4 write", 1, 1, 0, 0, 1, 6'd20, 8'h11, 1, 6'd21, 8'h22);
    step("R4 write", 1, 1, 0, 0, 1, 6'd21, 8'h33, 1, 6'd20, 8'h44);
    rd("R4 readback", 6'd20, 6'd20);
    rd("R4 readback", 6'd21, 6'd21);
    rd("R4 readback", 6'd21, 6'd21);

    // R2 enable low blocks write
    step("R2 blocked write", 0, 1, 0, 0, 1, 6'd9, 8'ha5, 1, 6'd9, 8'h5a);
    step("R2 blocked write", 0, 1, 0, 0, 0, 6'd44, 8'h00, 0, 6'd7, 8'h00);
    rd("R2 readback", 6'd9, 6'd9);
    rd("R2 readback", 6'd9, 6'd9);

    // R6 output enable low holds q
    rd("R6 prime", 6'd50, 6'd10);
    rd("R6 prime", 6'd51, 6'd11);
    step("R6 hold", 1, 0, 0, 0, 0, 6'd52, '0, 0, 6'd12, '0);
    step("R6 hold", 1, 0, 0, 0, 0, 6'd53, '0, 0, 6'd13, '0);
    rd("R6 resume", 6'd53, 6'd13);

    // R1 async output clear, contents kept
    step("R1 clear", 1, 1, 0, 1, 0, 6'd7, '0, 0, 6'd7, '0);
    rd("R1 contents kept", 6'd7, 6'd7);
    rd("R1 contents kept", 6'd7, 6'd7);

    // R7 input clear blocks write and clears address
    rd("R7 prime", 6'd40, 6'd15);
    step("R7 clear", 1, 1, 1, 0, 1, 6'd40, 8'h77, 1, 6'd15, 8'h88);
    step("R7 after clear", 0, 1, 0, 0, 0, 6'd33, '0, 0, 6'd33, '0);
    rd("R7 readback", 6'd40, 6'd15);
    rd("R7 readback", 6'd40, 6'd15);

    // R8 halves isolated at the same address value
    step("R8 both write", 1, 1, 0, 0, 1, 6'd5, 8'h9a, 1, 6'd5, 8'hb6);
    rd("R8 readback", 6'd5, 6'd5);
    step("R8 A only", 1, 1, 0, 0, 1, 6'd6, 8'he1, 0, 6'd6, '0);
    rd("R8 B untouched", 6'd6, 6'd6);
    rd("R8 readback", 6'd6, 6'd6);

    // Constrained random mix
    for (int k = 0; k < 600; k++) begin
      bit ce, oce, iclr, oclr, awe, bwe;
      ce   = ($urandom % 8) != 0;
      oce  = ($urandom % 12) != 0;
      iclr = ($urandom % 64) == 0;
      oclr = ($urandom % 64) == 0;
      awe  = ($urandom % 3) == 0;
      bwe  = ($urandom % 3) == 0;
      step("R3 R5 random", ce, oce, iclr, oclr,
           awe, AW'($urandom), DW'($urandom), bwe, AW'($urandom), DW'($urandom));
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

endmodule